// File: doc/BRIEF.md
# Prescaled Single-Slope PWM Timer with Three Compare Outputs

The block is a 16-bit up-counter behind an 8-bit register bus. A clock-select field picks one of five divide ratios of the system clock, or stops counting. The counter runs in single-slope fast PWM. The wrap point (TOP) is held in its own period register, so all three compare registers are left for the three PWM pins. Each pin has its own output mode: non-inverting, inverting or disconnected.

The counter raises an overflow flag on every wrap. The flag can be masked onto an interrupt line, and software clears it by writing 1 to it. The bus is one byte wide, so each 16-bit register is reached as a low and a high byte. A single temporary byte is shared by all of them: a high-byte write lands in the temporary byte, and the following low-byte write commits all 16 bits in one clock. Reading a low byte copies the matching high byte into the temporary byte, so the next high-byte read returns a coherent value.

Firmware normally proceeds in this order: stop the clock, clear the counter, load TOP and the compare values, set the channel modes, and then select a clock divider to start.

Top module: `fpwm_timer16`

## Requirements
- R1: After reset every register reads 0, all three PWM pins are 0 and the interrupt line is 0.
- R2: Control byte B bits 2:0 select the count rate: 001 every clock, 010 every 8, 011 every 64, 100 every 256, 101 every 1024. Values 000, 110 and 111 stop the count. The divider restarts from zero whenever counting is stopped, so a pin period is (TOP+1) times the divide ratio.
- R3: While stopped, the counter holds its value.
- R4: On a tick with count equal to TOP the counter returns to 0, so one period is TOP+1 ticks for any TOP, including TOP = 0.
- R5: The waveform mode is {control B bits 4:3, control A bits 1:0}. Only 1110 (fast PWM, TOP from the period register) enables the pins; any other value forces all pins to 0.
- R6: Control A holds the output modes: bits 7:6 for pin 0, bits 5:4 for pin 1, bits 3:2 for pin 2. Mode 10 sets the pin at the wrap and clears it on the tick where the count equals the compare value, which gives min(compare+1, TOP+1) high ticks per period. Mode 11 is the inverse of mode 10. Modes 00 and 01 drive 0.
- R7: Address map: 0 control A, 1 control B, 2/3 counter low/high, 4/5 period low/high, 6/7, 8/9 and 10/11 compare 0/1/2 low/high, 12 interrupt mask, 13 flag. A high-byte write only loads the shared temporary byte, and a low-byte write commits {temporary, data} in one clock. A low-byte read loads the temporary byte with the committed high byte, and a high-byte read returns the temporary byte.
- R8: A compare write takes effect at the next wrap, never within the running period.
- R9: Flag bit 2 is set on each wrap. Writing 1 to it clears it and writing 0 has no effect; a set in the same clock as a clear wins.
- R10: The interrupt line is flag bit 2 AND mask bit 2. The other mask bits are stored and read back unchanged and have no effect on the line.
- R11: Control B bits 7:5 always read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one clock per access |
| rd_i | input | 1 | Read strobe, updates the temporary byte on low-byte reads |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| pwm_o | output | 3 | PWM pins, bit i is channel i |
| irq_o | output | 1 | Overflow interrupt |

## Verification
A wrong count or TOP shows on the pins within one period: the rise-to-rise spacing moves away from (TOP+1) times the divide ratio. A stale or early-loaded compare value changes the number of high samples in a one-period window, or the length of the period in which the write was made. A bad temporary byte shows at the next read-back as a half-committed word. A flag or mask fault shows on irq_o in the cycle after the register write.

// File: rtl/fpt_pkg.sv
package fpt_pkg;
  localparam int BUS_W  = 8;
  localparam int CNT_W  = 2 * BUS_W;
  localparam int N_CH   = 3;
  localparam int PSC_W  = 10;
  localparam int ADDR_W = 4;
  localparam int CS_W   = 3;
  localparam int MODE_W = 2;
  localparam int CTLB_W = 5;
  localparam int N_WIDE = 2 + N_CH;
  localparam int OVF_BIT = 2;

  localparam logic [ADDR_W-1:0] ADR_CTRL_A = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_CTRL_B = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_CNT_L  = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_TOP_L  = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_IMSK   = 4'd12;
  localparam logic [ADDR_W-1:0] ADR_IFLG   = 4'd13;
  localparam logic [ADDR_W-1:0] ADR_WIDE_LAST = ADR_CNT_L + ADDR_W'(2 * N_WIDE - 1);

  localparam logic [3:0] WAVE_FPWM_TOP = 4'b1110;

  function automatic logic cs_runs(input logic [CS_W-1:0] cs);
    return (cs >= 3'd1) && (cs <= 3'd5);
  endfunction

  function automatic logic [PSC_W-1:0] psc_limit(input logic [CS_W-1:0] cs);
    case (cs)
      3'd2:    return PSC_W'(7);
      3'd3:    return PSC_W'(63);
      3'd4:    return PSC_W'(255);
      3'd5:    return PSC_W'(1023);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/fpt_prescaler.sv
module fpt_prescaler
  import fpt_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CS_W-1:0] cs_i,
  output logic            tick_o
);
  logic [PSC_W-1:0] psc_q;
  logic             run;

  assign run    = cs_runs(cs_i);
  assign tick_o = run && (psc_q >= psc_limit(cs_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      psc_q <= '0;
    else if (!run)    psc_q <= '0;
    else if (tick_o)  psc_q <= '0;
    else              psc_q <= psc_q + 1'b1;
  end

  // R2: at divide-by-8 two ticks are never adjacent
  a_r2_div8_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && cs_i == 3'd2 && $past(cs_i) == 3'd2) |-> !$past(tick_o));
endmodule

// File: rtl/fpt_counter.sv
module fpt_counter
  import fpt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wval_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i && !we_i && (cnt_q == top_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (we_i)    cnt_q <= wval_i;
    else if (wrap_o)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  a_r3_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !we_i) |=> $stable(cnt_o));
  a_r4_wrap_returns_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_o == '0));
  a_r7_word_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (cnt_o == $past(wval_i)));
endmodule

// File: rtl/fpt_channel.sv
module fpt_channel
  import fpt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wrap_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  cmp_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              wave_ok_i,
  output logic              pwm_o
);
  logic [CNT_W-1:0] cmp_act_q;
  logic             lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmp_act_q <= '0;
    else if (wrap_i) cmp_act_q <= cmp_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            lvl_q <= 1'b0;
    else if (wrap_i)                        lvl_q <= 1'b1;
    else if (tick_i && cnt_i == cmp_act_q)  lvl_q <= 1'b0;
  end

  assign pwm_o = wave_ok_i && mode_i[1] && (lvl_q ^ mode_i[0]);

  a_r8_cmp_only_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> $stable(cmp_act_q));
  a_r6_set_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> lvl_q);
endmodule

// File: rtl/fpt_regs.sv
module fpt_regs
  import fpt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              wrap_i,
  output logic              cnt_we_o,
  output logic [CNT_W-1:0]  cnt_wval_o,
  output logic [BUS_W-1:0]  ctrl_a_o,
  output logic [CTLB_W-1:0] ctrl_b_o,
  output logic [CNT_W-1:0]  top_o,
  output logic [CNT_W-1:0]  cmp_o [N_CH],
  output logic              irq_o
);
  logic [BUS_W-1:0]  ctrl_a_q, imsk_q, tmp_q;
  logic [CTLB_W-1:0] ctrl_b_q;
  logic [CNT_W-1:0]  top_q;
  logic [CNT_W-1:0]  cmp_q [N_CH];
  logic              ovf_q;

  logic              wide, is_lo, is_hi;
  logic [ADDR_W-1:0] woff;
  logic [ADDR_W-2:0] wsel;
  logic [CNT_W-1:0]  word [N_WIDE];
  logic [CNT_W-1:0]  rd_word;

  assign wide  = (addr_i >= ADR_CNT_L) && (addr_i <= ADR_WIDE_LAST);
  assign is_hi = wide && addr_i[0];
  assign is_lo = wide && !addr_i[0];
  assign woff  = addr_i - ADR_CNT_L;
  assign wsel  = woff[ADDR_W-1:1];

  assign word[0] = cnt_i;
  assign word[1] = top_q;
  for (genvar g = 0; g < N_CH; g++) begin : g_cmp
    assign word[2+g] = cmp_q[g];
    assign cmp_o[g]  = cmp_q[g];
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < N_WIDE; i++)
      if (wsel == (ADDR_W-1)'(i)) rd_word = word[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_a_q <= '0;
      ctrl_b_q <= '0;
      imsk_q   <= '0;
      tmp_q    <= '0;
      top_q    <= '0;
      for (int i = 0; i < N_CH; i++) cmp_q[i] <= '0;
    end else if (wr_i) begin
      if (addr_i == ADR_CTRL_A) ctrl_a_q <= wdata_i;
      if (addr_i == ADR_CTRL_B) ctrl_b_q <= wdata_i[CTLB_W-1:0];
      if (addr_i == ADR_IMSK)   imsk_q   <= wdata_i;
      if (is_hi)                tmp_q    <= wdata_i;
      if (is_lo && wsel == (ADDR_W-1)'(1)) top_q <= {tmp_q, wdata_i};
      for (int i = 0; i < N_CH; i++)
        if (is_lo && wsel == (ADDR_W-1)'(2 + i)) cmp_q[i] <= {tmp_q, wdata_i};
    end else if (rd_i && is_lo) begin
      tmp_q <= rd_word[CNT_W-1:BUS_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ovf_q <= 1'b0;
    else if (wrap_i) ovf_q <= 1'b1;
    else if (wr_i && addr_i == ADR_IFLG && wdata_i[OVF_BIT]) ovf_q <= 1'b0;
  end

  assign cnt_we_o   = wr_i && is_lo && (wsel == '0);
  assign cnt_wval_o = {tmp_q, wdata_i};
  assign ctrl_a_o   = ctrl_a_q;
  assign ctrl_b_o   = ctrl_b_q;
  assign top_o      = top_q;
  assign irq_o      = ovf_q && imsk_q[OVF_BIT];

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADR_CTRL_A)      rdata_o = ctrl_a_q;
    else if (addr_i == ADR_CTRL_B) rdata_o = BUS_W'(ctrl_b_q);
    else if (addr_i == ADR_IMSK)   rdata_o = imsk_q;
    else if (addr_i == ADR_IFLG)   rdata_o = BUS_W'(ovf_q) << OVF_BIT;
    else if (is_lo)                rdata_o = rd_word[BUS_W-1:0];
    else if (is_hi)                rdata_o = tmp_q;
  end

  a_r7_high_byte_no_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADR_TOP_L + 4'd1) |=> $stable(top_q));
  a_r9_flag_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> ovf_q);
  a_r9_zero_write_keeps_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && wr_i && addr_i == ADR_IFLG && !wdata_i[OVF_BIT]) |=> ovf_q);
endmodule

// File: rtl/fpwm_timer16.sv
module fpwm_timer16
  import fpt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [3:0]  addr_i,
  input  logic [7:0]  wdata_i,
  input  logic        wr_i,
  input  logic        rd_i,
  output logic [7:0]  rdata_o,
  output logic [2:0]  pwm_o,
  output logic        irq_o
);
  logic [BUS_W-1:0]  ctrl_a;
  logic [CTLB_W-1:0] ctrl_b;
  logic [CNT_W-1:0]  top, cnt, cnt_wval;
  logic [CNT_W-1:0]  cmp [N_CH];
  logic              cnt_we, tick, wrap, wave_ok;

  assign wave_ok = ({ctrl_b[4:3], ctrl_a[1:0]} == WAVE_FPWM_TOP);

  fpt_regs u_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .wr_i, .rd_i, .rdata_o,
    .cnt_i(cnt), .wrap_i(wrap), .cnt_we_o(cnt_we), .cnt_wval_o(cnt_wval),
    .ctrl_a_o(ctrl_a), .ctrl_b_o(ctrl_b), .top_o(top), .cmp_o(cmp), .irq_o
  );

  fpt_prescaler u_psc (.clk_i, .rst_ni, .cs_i(ctrl_b[CS_W-1:0]), .tick_o(tick));

  fpt_counter u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .top_i(top), .we_i(cnt_we),
    .wval_i(cnt_wval), .cnt_o(cnt), .wrap_o(wrap)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    fpt_channel u_ch (
      .clk_i, .rst_ni, .tick_i(tick), .wrap_i(wrap), .cnt_i(cnt), .cmp_i(cmp[g]),
      .mode_i(ctrl_a[BUS_W-1-MODE_W*g -: MODE_W]), .wave_ok_i(wave_ok), .pwm_o(pwm_o[g])
    );
  end

  // R5: pins stay low outside fast-PWM-with-period-TOP
  a_r5_pins_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wave_ok |-> (pwm_o == '0));
endmodule

// File: tb/fpwm_timer16_tb.sv
module fpwm_timer16_tb;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic [3:0] addr;
  logic [7:0] wdata;
  logic       wr, rd;
  logic [7:0] rdata;
  logic [2:0] pwm;
  logic       irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fpwm_timer16 u_dut (.clk_i(clk), .rst_ni, .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .pwm_o(pwm), .irq_o(irq));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_b(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_b(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] lo, input logic [15:0] v);
    wr_b(lo + 4'd1, v[15:8]);
    wr_b(lo, v[7:0]);
  endtask

  task automatic rd16(input logic [3:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    rd_b(lo, l);
    rd_b(lo + 4'd1, h);
    v = {h, l};
  endtask

  task automatic setup(input logic [2:0] cs, input logic [15:0] top, input logic [7:0] ca,
                       input logic [15:0] c0, input logic [15:0] c1, input logic [15:0] c2);
    wr_b(4'd1, 8'h18);
    wr16(4'd2, 16'd0);
    wr16(4'd4, top);
    wr16(4'd6, c0);
    wr16(4'd8, c1);
    wr16(4'd10, c2);
    wr_b(4'd0, ca);
    wr_b(4'd1, 8'h18 | {5'd0, cs});
  endtask

  task automatic window(input int n, output int h0, output int h1, output int h2);
    h0 = 0; h1 = 0; h2 = 0;
    repeat (n) begin
      @(negedge clk);
      h0 += int'(pwm[0]); h1 += int'(pwm[1]); h2 += int'(pwm[2]);
    end
  endtask

  task automatic find_rise();
    while (pwm[0] !== 1'b0) @(negedge clk);
    while (pwm[0] !== 1'b1) @(negedge clk);
  endtask

  // from a rise of pin 0: high samples and samples up to the next rise
  task automatic measure(output int hl, output int per);
    bit seen_low;
    find_rise();
    hl = 1; per = 1; seen_low = 0;
    while (1) begin
      @(negedge clk);
      if (pwm[0] === 1'b1) begin
        if (seen_low) break;
        hl++;
      end else seen_low = 1;
      per++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w;
    int h0, h1, h2, hl, per, ea;
    rst_ni = 1'b0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    for (int a = 0; a < 14; a++) begin
      rd_b(4'(a), b);
      chk($sformatf("R1 reg %0d", a), b, 0);
    end
    chk("R1 pins", pwm, 0);
    chk("R1 irq", irq, 0);

    // R6 duty sweep, pin0 mode 10, pin1 mode 11, pin2 mode 10 fixed compare 4
    setup(3'd1, 16'd9, 8'hBA, 16'd0, 16'd0, 16'd4);
    for (int c = 0; c < 12; c++) begin
      wr16(4'd6, 16'(c));
      wr16(4'd8, 16'(c));
      repeat (25) @(negedge clk);
      window(10, h0, h1, h2);
      ea = (c + 1 < 10) ? c + 1 : 10;
      chk($sformatf("R6 noninv cmp=%0d", c), h0, ea);
      chk($sformatf("R6 inv cmp=%0d", c), h1, 10 - ea);
      chk($sformatf("R6 fixed cmp4 c=%0d", c), h2, 5);
    end

    // R4 TOP sweep including TOP=0
    for (int t = 0; t < 7; t++) begin
      setup(3'd1, 16'(t), 8'hBA, 16'd2, 16'd2, 16'd2);
      repeat (3 * (t + 1) + 8) @(negedge clk);
      window(t + 1, h0, h1, h2);
      ea = (t + 1 < 3) ? t + 1 : 3;
      chk($sformatf("R4 top=%0d noninv", t), h0, ea);
      chk($sformatf("R4 top=%0d inv", t), h1, t + 1 - ea);
    end

    // R6 modes 00 and 01 drive 0
    setup(3'd1, 16'd9, 8'h1A, 16'd4, 16'd4, 16'd4);
    repeat (25) @(negedge clk);
    window(10, h0, h1, h2);
    chk("R6 mode00", h0, 0);
    chk("R6 mode01", h1, 0);
    chk("R6 mode10 alongside", h2, 5);

    // R5 wrong waveform mode
    wr_b(4'd0, 8'hB8);
    window(20, h0, h1, h2);
    chk("R5 ctrlA low bits 00", h0 + h1 + h2, 0);
    wr_b(4'd0, 8'hBA);
    wr_b(4'd1, 8'h09);
    window(20, h0, h1, h2);
    chk("R5 ctrlB bits 4:3 = 01", h0 + h1 + h2, 0);

    // R2 divider ratios, TOP=3, compare 1
    for (int cs = 1; cs <= 5; cs++) begin
      int div;
      div = (cs == 1) ? 1 : (cs == 2) ? 8 : (cs == 3) ? 64 : (cs == 4) ? 256 : 1024;
      setup(3'(cs), 16'd3, 8'h82, 16'd1, 16'd0, 16'd0);
      measure(hl, per);
      measure(hl, per);
      chk($sformatf("R2 period cs=%0d", cs), per, 4 * div);
      chk($sformatf("R2 high cs=%0d", cs), hl, 2 * div);
    end

    // R3 / R7 counter access while stopped
    wr_b(4'd1, 8'h18);
    wr16(4'd2, 16'h1234);
    rd16(4'd2, w);
    chk("R7 counter readback", w, 16'h1234);
    repeat (50) @(negedge clk);
    rd16(4'd2, w);
    chk("R3 stopped counter holds", w, 16'h1234);
    wr_b(4'd3, 8'hAB);
    rd_b(4'd2, b);
    chk("R7 high write alone no commit", b, 8'h34);
    rd_b(4'd3, b);
    chk("R7 low read reloads temp", b, 8'h12);

    // R2 codes 110 and 111 stop; R11 reserved bits
    wr_b(4'd1, 8'h1E);
    repeat (40) @(negedge clk);
    rd16(4'd2, w);
    chk("R2 cs=110 stopped", w, 16'h1234);
    wr_b(4'd1, 8'hFF);
    rd_b(4'd1, b);
    chk("R11 ctrlB bits 7:5 zero", b, 8'h1F);
    repeat (40) @(negedge clk);
    rd16(4'd2, w);
    chk("R2 cs=111 stopped", w, 16'h1234);

    // R7 period high byte alone while running
    setup(3'd1, 16'd9, 8'h82, 16'd4, 16'd0, 16'd0);
    wr_b(4'd5, 8'h01);
    repeat (25) @(negedge clk);
    window(10, h0, h1, h2);
    chk("R7 top high byte alone, duty", h0, 5);
    rd16(4'd4, w);
    chk("R7 top unchanged", w, 9);

    // R8 compare change inside a period
    setup(3'd1, 16'd99, 8'h82, 16'd10, 16'd0, 16'd0);
    measure(hl, per);
    hl = 1;
    wr16(4'd6, 16'd50);
    hl += 4;
    while (1) begin
      @(negedge clk);
      if (pwm[0] !== 1'b1) break;
      hl++;
    end
    chk("R8 old compare kept this period", hl, 11);
    measure(hl, per);
    chk("R8 new compare next period", hl, 51);
    chk("R4 period top=99", per, 100);

    // R9 / R10 flag and mask
    setup(3'd1, 16'd9, 8'h82, 16'd4, 16'd0, 16'd0);
    repeat (30) @(negedge clk);
    wr_b(4'd1, 8'h18);
    rd_b(4'd13, b);
    chk("R9 flag set by wrap", b, 8'h04);
    chk("R10 irq masked off", irq, 0);
    wr_b(4'd12, 8'hFB);
    rd_b(4'd12, b);
    chk("R10 other mask bits kept", b, 8'hFB);
    chk("R10 other mask bits no irq", irq, 0);
    wr_b(4'd12, 8'hFF);
    chk("R10 irq enabled", irq, 1);
    wr_b(4'd13, 8'hFB);
    rd_b(4'd13, b);
    chk("R9 write 0 keeps flag", b, 8'h04);
    wr_b(4'd13, 8'h04);
    rd_b(4'd13, b);
    chk("R9 write 1 clears flag", b, 8'h00);
    chk("R10 irq drops", irq, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule